// File: doc/BRIEF.md
# DMA Command Queue and Line Splitter

This block sits between a local processor and the system bus. It takes transfer commands, each holding a local-store address, an effective (system) address, a byte count, a 5-bit tag and a direction bit. It checks every command against the size and alignment rules. A legal command goes into a 16-slot queue. An illegal command produces a one-cycle error pulse and is dropped.

The queue drains in arrival order. The command at the head is cut into bus requests. No request carries more than 128 bytes or crosses a 128-byte boundary of the effective address. A transfer that starts partway into a line therefore costs one extra request. A transfer that starts on a line boundary and has a line-multiple size needs exactly one full-line request per 128 bytes. When the final request of a command is accepted on the bus, the completion flag for that command's tag is set. Moving the data, address translation and coherence are done elsewhere.

Top module: `dma_cmd_splitter`

## Requirements
- R1: A command is legal only when its size is 1, 2, 4 or 8, or is a non-zero multiple of 16 no larger than 16384. A zero size, a size above 16384, or any other size is rejected. A rejected command pulses `cmd_err` high for exactly one cycle, in the cycle after the handshake, and emits no bus request.
- R2: For sizes 1, 2, 4 and 8, both addresses must be multiples of the size, and bits [3:0] of the two addresses must be equal. Otherwise the command is rejected as in R1.
- R3: For sizes that are multiples of 16, bits [3:0] of both addresses must be zero. Their upper bits need not match.
- R4: Up to 16 legal commands are held, including the one being split. While 16 are held, `cmd_ready` is low and no command is taken. It rises again once the head command completes.
- R5: Each request carries 1 to 128 bytes and stays inside one 128-byte line of `req_ea`. The byte count is the smaller of what remains and the distance from `req_ea` to the end of its line.
- R6: Within a command, the effective and local addresses of the next request both equal the previous ones plus the previous byte count. The byte counts add up to the command size.
- R7: Commands are split in arrival order, and the requests of one command appear back to back. `req_last` marks the final request of each command. `req_tag` and `req_dir` carry the command's tag and direction.
- R8: Bit t of `done_flags` becomes 1 in the cycle after the handshake of the final request of a command with tag t. It does not change on earlier requests. It returns to 0 when a new legal command with tag t is accepted.
- R9: After reset, `cmd_ready` is 1 and `req_valid`, `cmd_err` and all of `done_flags` are 0.
- R10: While `req_valid` is high and `req_ready` is low, every request output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle if valid; low when the queue is full |
| cmd_ea | input | 32 | Effective (system) address |
| cmd_ls | input | 18 | Local-store address |
| cmd_size | input | 15 | Transfer size in bytes |
| cmd_tag | input | 5 | Completion tag |
| cmd_dir | input | 1 | Transfer direction, carried to the requests |
| cmd_err | output | 1 | One-cycle pulse after an illegal command is taken |
| req_valid | output | 1 | Bus request present |
| req_ready | input | 1 | Bus accepts the request |
| req_ea | output | 32 | Request effective address |
| req_ls | output | 18 | Request local-store address |
| req_bytes | output | 8 | Request byte count, 1 to 128 |
| req_tag | output | 5 | Tag of the owning command |
| req_dir | output | 1 | Direction of the owning command |
| req_last | output | 1 | Final request of the command |
| done_flags | output | 32 | One completion flag per tag |

## Verification
The bound checker examines every cycle for the following:
- each request keeps inside one line and carries 1 to 128 bytes;
- consecutive requests of one command advance both addresses by the previous byte count;
- a stalled request holds steady;
- an error pulse only follows a taken command;
- a completion flag rises only for the tag of the final request accepted in the cycle before.

Other behaviours depend on what the bench sent, so only its directed scenarios can show them. These are the legality decisions for each size and alignment class, the exact number of requests for aligned and misaligned transfers, arrival order across a full queue, refusal of a seventeenth command, and a flag clearing when its tag is reused.

// File: rtl/dma_split_pkg.sv
`timescale 1ns/1ps
package dma_split_pkg;
  localparam int EA_W     = 32;
  localparam int LS_W     = 18;
  localparam int SIZE_W   = 15;
  localparam int TAG_W    = 5;
  localparam int LINE_B   = 128;
  localparam int MAX_XFER = 16384;
  localparam int ALW      = 4;                 // low-address bits compared for small moves
  localparam int LINE_LW  = $clog2(LINE_B);
  localparam int CHUNK_W  = LINE_LW + 1;
  localparam int NTAGS    = 1 << TAG_W;

  typedef struct packed {
    logic [EA_W-1:0]   ea;
    logic [LS_W-1:0]   ls;
    logic [SIZE_W-1:0] size;
    logic [TAG_W-1:0]  tag;
    logic              dir;
  } dma_cmd_t;
endpackage

// File: rtl/dma_cmd_check.sv
`timescale 1ns/1ps
module dma_cmd_check
  import dma_split_pkg::*;
(
  input  dma_cmd_t cmd,
  output logic     legal
);
  logic           is_small, is_mult16, in_range, small_ok, blk_ok;
  logic [ALW-1:0] amask;

  always_comb begin
    is_small  = (cmd.size == SIZE_W'(1)) || (cmd.size == SIZE_W'(2)) ||
                (cmd.size == SIZE_W'(4)) || (cmd.size == SIZE_W'(8));
    is_mult16 = (cmd.size[ALW-1:0] == '0) && (cmd.size != '0);
    in_range  = cmd.size <= SIZE_W'(MAX_XFER);
    amask     = cmd.size[ALW-1:0] - ALW'(1);
    small_ok  = ((cmd.ea[ALW-1:0] & amask) == '0) &&
                ((cmd.ls[ALW-1:0] & amask) == '0) &&
                (cmd.ea[ALW-1:0] == cmd.ls[ALW-1:0]);
    blk_ok    = (cmd.ea[ALW-1:0] == '0) && (cmd.ls[ALW-1:0] == '0);
    legal     = in_range && (is_small ? small_ok : (is_mult16 && blk_ok));
  end
endmodule

// File: rtl/dma_cmd_fifo.sv
`timescale 1ns/1ps
module dma_cmd_fifo
  import dma_split_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  dma_cmd_t wdata,
  input  logic     pop,
  output dma_cmd_t rdata,
  output logic     full,
  output logic     empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  dma_cmd_t        mem [DEPTH];
  logic [PW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/dma_seg_engine.sv
`timescale 1ns/1ps
module dma_seg_engine
  import dma_split_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               head_valid,
  input  dma_cmd_t           head,
  input  logic               req_ready,
  output logic [EA_W-1:0]    req_ea,
  output logic [LS_W-1:0]    req_ls,
  output logic [CHUNK_W-1:0] req_bytes,
  output logic               req_last,
  output logic               pop
);
  logic [SIZE_W-1:0]  off_q, off_d, rem;
  logic [CHUNK_W-1:0] room;
  logic               fire;

  always_comb begin
    req_ea    = head.ea + EA_W'(off_q);
    req_ls    = head.ls + LS_W'(off_q);
    rem       = head.size - off_q;
    room      = CHUNK_W'(LINE_B) - {1'b0, req_ea[LINE_LW-1:0]};
    req_last  = rem <= SIZE_W'(room);
    req_bytes = req_last ? rem[CHUNK_W-1:0] : room;
    fire      = head_valid && req_ready;
    pop       = fire && req_last;
    off_d     = off_q;
    if (fire) off_d = req_last ? '0 : off_q + SIZE_W'(req_bytes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= off_d;
  end
endmodule

// File: rtl/dma_done_track.sv
`timescale 1ns/1ps
module dma_done_track
  import dma_split_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  output logic [NTAGS-1:0] flags
);
  logic [NTAGS-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (set_en) flags_d[set_tag] = 1'b1;
    if (clr_en) flags_d[clr_tag] = 1'b0;   // a fresh command with the tag wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/dma_cmd_splitter.sv
`timescale 1ns/1ps
module dma_cmd_splitter
  import dma_split_pkg::*;
#(
  parameter int QDEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [EA_W-1:0]    cmd_ea,
  input  logic [LS_W-1:0]    cmd_ls,
  input  logic [SIZE_W-1:0]  cmd_size,
  input  logic [TAG_W-1:0]   cmd_tag,
  input  logic               cmd_dir,
  output logic               cmd_err,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [EA_W-1:0]    req_ea,
  output logic [LS_W-1:0]    req_ls,
  output logic [CHUNK_W-1:0] req_bytes,
  output logic [TAG_W-1:0]   req_tag,
  output logic               req_dir,
  output logic               req_last,
  output logic [NTAGS-1:0]   done_flags
);
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  dma_cmd_t in_cmd, head;
  logic     legal, accept, push, pop, full, empty, err_d, err_q;

  assign in_cmd = '{ea: cmd_ea, ls: cmd_ls, size: cmd_size, tag: cmd_tag, dir: cmd_dir};

  dma_cmd_check u_check (.cmd(in_cmd), .legal(legal));

  assign cmd_ready = srst_n && !full;
  assign accept    = cmd_valid && cmd_ready;
  assign push      = accept && legal;
  assign err_d     = accept && !legal;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) err_q <= 1'b0;
    else         err_q <= err_d;
  end
  assign cmd_err = err_q;

  dma_cmd_fifo #(.DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(srst_n), .push(push), .wdata(in_cmd),
    .pop(pop), .rdata(head), .full(full), .empty(empty)
  );

  assign req_valid = !empty;
  assign req_tag   = head.tag;
  assign req_dir   = head.dir;

  dma_seg_engine u_seg (
    .clk(clk), .rst_n(srst_n), .head_valid(req_valid), .head(head),
    .req_ready(req_ready), .req_ea(req_ea), .req_ls(req_ls),
    .req_bytes(req_bytes), .req_last(req_last), .pop(pop)
  );

  dma_done_track u_done (
    .clk(clk), .rst_n(srst_n),
    .set_en(pop), .set_tag(head.tag),
    .clr_en(push), .clr_tag(cmd_tag),
    .flags(done_flags)
  );
endmodule

// File: rtl/dma_split_checker.sv
`timescale 1ns/1ps
module dma_split_checker
  import dma_split_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               cmd_err,
  input logic               req_valid,
  input logic               req_ready,
  input logic [EA_W-1:0]    req_ea,
  input logic [LS_W-1:0]    req_ls,
  input logic [CHUNK_W-1:0] req_bytes,
  input logic [TAG_W-1:0]   req_tag,
  input logic               req_last,
  input logic [NTAGS-1:0]   done_flags
);
  assert_chunk_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bytes != '0) && (req_bytes <= CHUNK_W'(LINE_B)));

  assert_no_line_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (({1'b0, req_ea[LINE_LW-1:0]} + req_bytes) <= CHUNK_W'(LINE_B)));

  assert_addr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_last) |=>
      (req_valid && (req_ea == $past(req_ea) + EA_W'($past(req_bytes))) &&
       (req_ls == $past(req_ls) + LS_W'($past(req_bytes))) &&
       (req_tag == $past(req_tag))));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_ea) && $stable(req_ls) && $stable(req_bytes) &&
       $stable(req_tag) && $stable(req_last)));

  assert_err_after_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && cmd_ready));

  assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_flags & ~$past(done_flags)) != '0) |->
      ($past(req_valid && req_ready && req_last) &&
       ((done_flags & ~$past(done_flags)) == (NTAGS'(1) << $past(req_tag)))));
endmodule

bind dma_cmd_splitter dma_split_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_err(cmd_err), .req_valid(req_valid), .req_ready(req_ready),
  .req_ea(req_ea), .req_ls(req_ls), .req_bytes(req_bytes), .req_tag(req_tag),
  .req_last(req_last), .done_flags(done_flags)
);

// File: tb/dma_cmd_splitter_test.sv
`timescale 1ns/1ps
module dma_cmd_splitter_test;
  import dma_split_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cmd_valid, cmd_ready, cmd_dir, cmd_err;
  logic [EA_W-1:0]    cmd_ea;
  logic [LS_W-1:0]    cmd_ls;
  logic [SIZE_W-1:0]  cmd_size;
  logic [TAG_W-1:0]   cmd_tag;
  logic               req_valid, req_ready, req_dir, req_last;
  logic [EA_W-1:0]    req_ea;
  logic [LS_W-1:0]    req_ls;
  logic [CHUNK_W-1:0] req_bytes;
  logic [TAG_W-1:0]   req_tag;
  logic [NTAGS-1:0]   done_flags;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dma_cmd_splitter uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_ea(cmd_ea), .cmd_ls(cmd_ls), .cmd_size(cmd_size), .cmd_tag(cmd_tag),
    .cmd_dir(cmd_dir), .cmd_err(cmd_err), .req_valid(req_valid),
    .req_ready(req_ready), .req_ea(req_ea), .req_ls(req_ls),
    .req_bytes(req_bytes), .req_tag(req_tag), .req_dir(req_dir),
    .req_last(req_last), .done_flags(done_flags)
  );

  // request log, filled at the falling edge ahead of each accepting rising edge
  logic [EA_W-1:0]  lg_ea   [256];
  logic [LS_W-1:0]  lg_ls   [256];
  int               lg_by   [256];
  logic             lg_last [256];
  logic [TAG_W-1:0] lg_tag  [256];
  int               lg_n;

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && lg_n < 256) begin
      lg_ea[lg_n]   = req_ea;
      lg_ls[lg_n]   = req_ls;
      lg_by[lg_n]   = int'(req_bytes);
      lg_last[lg_n] = req_last;
      lg_tag[lg_n]  = req_tag;
      lg_n          = lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(posedge clk); #1;
    lg_n = 0;
  endtask

  task automatic send(input longint ea, input longint ls, input int size,
                      input int tag, output bit acc, output bit err);
    @(posedge clk); #1;
    cmd_valid = 1'b1;
    cmd_ea    = EA_W'(ea);
    cmd_ls    = LS_W'(ls);
    cmd_size  = SIZE_W'(size);
    cmd_tag   = TAG_W'(tag);
    cmd_dir   = tag[0];
    @(negedge clk);
    acc = cmd_ready;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    err = cmd_err;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!req_valid) break;
    end
  endtask

  task automatic pulse_ready();
    @(posedge clk); #1;
    req_ready = 1'b1;
    @(posedge clk); #1;
    req_ready = 1'b0;
    @(negedge clk);
  endtask

  // expected split computed from the line rule: min(remaining, 128 - ea mod 128)
  task automatic check_segs(input int base, input longint ea, input longint ls,
                            input int size, input int tag, input string rq);
    longint e = ea;
    longint l = ls;
    int rem = size;
    int idx = base;
    while (rem > 0) begin
      int room = 128 - int'(e % 128);
      int c = (rem < room) ? rem : room;
      chk(idx < lg_n, rq, "request present", lg_n, idx + 1);
      if (idx < lg_n) begin
        chk(lg_ea[idx] == EA_W'(e), "R5", "req_ea", lg_ea[idx], e);
        chk(lg_ls[idx] == LS_W'(l), "R6", "req_ls", lg_ls[idx], l);
        chk(lg_by[idx] == c, "R5", "req_bytes", lg_by[idx], c);
        chk(lg_last[idx] == (rem == c), "R7", "req_last", lg_last[idx], rem == c);
        chk(lg_tag[idx] == TAG_W'(tag), "R7", "req_tag", lg_tag[idx], tag);
      end
      e += c; l += c; rem -= c; idx++;
    end
  endtask

  task automatic expect_reject(input longint ea, input longint ls, input int size,
                               input string rq);
    bit acc, err;
    clear_log();
    send(ea, ls, size, 30, acc, err);
    chk(acc, rq, "reject taken", acc, 1);
    chk(err, rq, "cmd_err pulse", err, 1);
    @(negedge clk);
    chk(!cmd_err, rq, "cmd_err one cycle", cmd_err, 0);
    chk(!req_valid && lg_n == 0, rq, "no request", lg_n, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; req_ready = 1'b0;
    cmd_ea = '0; cmd_ls = '0; cmd_size = '0; cmd_tag = '0; cmd_dir = 1'b0;
    lg_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "cmd_ready", cmd_ready, 1);
    chk(req_valid == 1'b0, "R9", "req_valid", req_valid, 0);
    chk(cmd_err == 1'b0, "R9", "cmd_err", cmd_err, 0);
    chk(done_flags == '0, "R9", "done_flags", done_flags, 0);
  endtask

  task automatic t_aligned();
    bit acc, err;
    req_ready = 1'b1;
    clear_log();
    send(64'h1000, 64'h200, 256, 3, acc, err);
    chk(acc && !err, "R1", "aligned 256 legal", err, 0);
    wait_idle();
    chk(lg_n == 2, "R5", "full-line request count", lg_n, 2);
    check_segs(0, 64'h1000, 64'h200, 256, 3, "R6");
    chk(done_flags[3], "R8", "done tag3", done_flags[3], 1);
  endtask

  task automatic t_misaligned();
    bit acc, err;
    clear_log();
    send(64'h1040, 64'h40, 128, 4, acc, err);
    wait_idle();
    chk(lg_n == 2, "R5", "misaligned line count", lg_n, 2);
    check_segs(0, 64'h1040, 64'h40, 128, 4, "R5");
    clear_log();
    send(64'h3070, 64'h10, 48, 5, acc, err);
    wait_idle();
    chk(lg_n == 2, "R5", "48 byte tail split", lg_n, 2);
    check_segs(0, 64'h3070, 64'h10, 48, 5, "R5");
  endtask

  task automatic t_small();
    bit acc, err;
    clear_log();
    send(64'h2004, 64'h14, 4, 6, acc, err);
    send(64'h2007, 64'h37, 1, 8, acc, err);
    chk(acc && !err, "R2", "odd byte legal", err, 0);
    wait_idle();
    chk(lg_n == 2, "R2", "small request count", lg_n, 2);
    check_segs(0, 64'h2004, 64'h14, 4, 6, "R2");
    check_segs(1, 64'h2007, 64'h37, 1, 8, "R2");
    expect_reject(64'h2004, 64'h8, 4, "R2");
    expect_reject(64'h2004, 64'h4, 8, "R2");
  endtask

  task automatic t_bad_size();
    bit acc, err;
    expect_reject(64'h1000, 64'h0, 0, "R1");
    expect_reject(64'h1000, 64'h0, 3, "R1");
    expect_reject(64'h1000, 64'h0, 24, "R1");
    expect_reject(64'h1000, 64'h0, 16400, "R1");
    expect_reject(64'h1008, 64'h8, 32, "R3");
    clear_log();
    send(64'h1010, 64'h20, 32, 9, acc, err);
    chk(acc && !err, "R3", "16-aligned unequal upper bits legal", err, 0);
    wait_idle();
    check_segs(0, 64'h1010, 64'h20, 32, 9, "R3");
  endtask

  task automatic t_max();
    bit acc, err;
    clear_log();
    send(64'h10000, 64'h0, 16384, 2, acc, err);
    chk(acc && !err, "R1", "16384 legal", err, 0);
    wait_idle();
    chk(lg_n == 128, "R1", "max transfer request count", lg_n, 128);
    check_segs(0, 64'h10000, 64'h0, 16384, 2, "R6");
  endtask

  task automatic t_full();
    bit acc, err;
    logic [EA_W-1:0] held;
    req_ready = 1'b0;
    for (int i = 0; i < 16; i++) begin
      send(64'h4000 + i * 16, 64'h100 + i * 16, 16, 10 + i, acc, err);
      chk(acc && !err, "R4", "queue slot", acc, 1);
    end
    @(negedge clk);
    chk(!cmd_ready, "R4", "cmd_ready low when full", cmd_ready, 0);
    send(64'h9000, 64'h0, 16, 31, acc, err);
    chk(!acc, "R4", "seventeenth refused", acc, 0);
    held = req_ea;
    repeat (3) @(negedge clk);
    chk(req_valid && req_ea == held, "R10", "stalled request held", req_ea, held);
    chk(done_flags[10] == 1'b0, "R8", "no done before ack", done_flags[10], 0);
    clear_log();
    req_ready = 1'b1;
    wait_idle();
    chk(lg_n == 16, "R7", "drained count", lg_n, 16);
    for (int i = 0; i < 16; i++) begin
      chk(lg_ea[i] == EA_W'(64'h4000 + i * 16), "R7", "arrival order ea",
          lg_ea[i], 64'h4000 + i * 16);
      chk(lg_tag[i] == TAG_W'(10 + i), "R7", "arrival order tag", lg_tag[i], 10 + i);
    end
    chk(done_flags[25:10] == 16'hffff, "R8", "all tags done", done_flags[25:10], 16'hffff);
    chk(cmd_ready, "R4", "cmd_ready back", cmd_ready, 1);
    chk(done_flags[31] == 1'b0, "R4", "refused tag never done", done_flags[31], 0);
  endtask

  task automatic t_done_clear();
    bit acc, err;
    req_ready = 1'b0;
    clear_log();
    send(64'h5000, 64'h300, 16, 3, acc, err);
    chk(done_flags[3] == 1'b0, "R8", "tag reuse clears flag", done_flags[3], 0);
    send(64'h6000, 64'h400, 256, 7, acc, err);
    pulse_ready();
    chk(done_flags[3] == 1'b1, "R8", "flag after last ack", done_flags[3], 1);
    chk(done_flags[7] == 1'b0, "R8", "tag7 not yet", done_flags[7], 0);
    pulse_ready();
    chk(done_flags[7] == 1'b0, "R8", "no flag on non-last ack", done_flags[7], 0);
    chk(lg_n == 2 && !lg_last[1], "R7", "first of tag7 not last", lg_last[1], 0);
    req_ready = 1'b1;
    wait_idle();
    chk(done_flags[7] == 1'b1, "R8", "tag7 done", done_flags[7], 1);
    check_segs(1, 64'h6000, 64'h400, 256, 7, "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_aligned();
    t_misaligned();
    t_small();
    t_bad_size();
    t_max();
    t_full();
    t_done_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule